// File: doc/BRIEF.md
# Read-Triggered Random Word Generator

This block keeps one 16-bit random word in a holding register for a processor to read. Each bit of the word comes from a nonlinear mix of four autonomous maximal-length shift registers (lengths 61, 67, 71 and 73, 272 stages in all) and a one-bit external entropy input. The entropy input is registered on every clock.

A read obtains the word only when the privilege qualifier is high at the same time. A privileged read of a ready word consumes it. The ready flag then drops, and a fresh word is assembled over a fixed 256 clocks. At a 40 MHz clock that is 6.4 us, inside a 480-cycle budget. A read without the qualifier returns zero and leaves everything as it was.

A word is built from 16 slots of 16 clocks. The combined bits of the clocks in a slot are folded by XOR into one parity bit. That parity bit is shifted in, so the first slot ends up as the most significant bit.

Top module: `rng_word_gen`

## Requirements
- R1: After reset the ready flag is low and a privileged read returns 0. The first word is ready exactly 256 clocks after reset is released.
- R2: `rd_data_o` shows the held word only while both `rd_en_i` and `priv_i` are high. In every other case it is zero.
- R3: A read with `priv_i` low does not change the ready flag or the held word.
- R4: A privileged read while the flag is high is accepted. The flag is low in the cycle after the accepting edge.
- R5: The flag rises again exactly 256 clocks after the accepting edge, which is never more than 480.
- R6: A privileged read while the flag is low returns the previous word and does not restart assembly. This also holds in the last cycle before completion.
- R7: The held word stays unchanged while the flag is low and while it is high with no accepted read. It is replaced only at completion.
- R8: Each word bit is the parity over its 16-clock slot of (nonlinear LFSR mix XOR registered entropy). Identical entropy streams from reset give identical words. Inverting one entropy sample inverts exactly one word bit. Inverting two samples in the same slot leaves the word unchanged.
- R9: No shift register ever holds all zeros (a zero next state reloads its seed). Successive words therefore keep changing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entropy_i | input | 1 | External entropy bit, sampled each clock |
| rd_en_i | input | 1 | Read strobe for the holding register |
| priv_i | input | 1 | Privileged-mode qualifier for the read |
| rd_data_o | output | 16 | Read data: held word or zero |
| valid_o | output | 1 | High while a complete unread word is held |

## Verification
A privileged read and the completion of a word can fall in the same cycle. The bench places a privileged read in the 256th cycle after an accepted read, while the flag is still low, and in the same cycle the fill finishes. The read must return the old word and must not be taken as a consume. The flag must be high afterwards, and the new word must still be there to peek. A second case places a busy read in mid-fill, and the completion time must stay at exactly 256 clocks.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int NUM_LFSR = 4;
  localparam int MAX_LEN  = 73;
  localparam int WORD_W   = 16;
  localparam int SLOT_CYC = 16;
  localparam int FILL_CYC = WORD_W * SLOT_CYC;
  localparam int FILL_W   = $clog2(FILL_CYC);
  localparam int SLOT_W   = $clog2(SLOT_CYC);
  localparam int TAP_A    = 0;
  localparam int TAP_B    = 7;
  localparam int TAP_C    = 13;

  typedef logic [MAX_LEN-1:0] lfsr_vec_t;

  localparam int LFSR_LEN [NUM_LFSR] = '{61, 67, 71, 73};

  // feedback tap masks: bit k set means stage k+1 feeds back
  localparam lfsr_vec_t LFSR_TAP [NUM_LFSR] = '{
    (lfsr_vec_t'(1) << 60) | (lfsr_vec_t'(1) << 59) | (lfsr_vec_t'(1) << 45) | (lfsr_vec_t'(1) << 44),
    (lfsr_vec_t'(1) << 66) | (lfsr_vec_t'(1) << 65) | (lfsr_vec_t'(1) << 57) | (lfsr_vec_t'(1) << 56),
    (lfsr_vec_t'(1) << 70) | (lfsr_vec_t'(1) << 64),
    (lfsr_vec_t'(1) << 72) | (lfsr_vec_t'(1) << 47)
  };

  localparam lfsr_vec_t LFSR_SEED [NUM_LFSR] = '{
    73'h0_1234_5678_9ABC_DEF1,
    73'h0_0F1E_2D3C_4B5A_6978,
    73'h1_A5A5_3C3C_0FF0_1357,
    73'h0_C0DE_FACE_BEEF_2468
  };

  // nonlinear mix of three tap samples from each register plus entropy
  function automatic logic mix_bit(logic [NUM_LFSR-1:0] a, logic [NUM_LFSR-1:0] b,
                                   logic [NUM_LFSR-1:0] c, logic e);
    logic prod, lin;
    prod = (a[0] & a[1]) ^ (a[2] & a[3]) ^ (b[0] & b[2]) ^ (b[1] | b[3]) ^ (c[0] & ~c[3]);
    lin  = c[1] ^ c[2];
    return prod ^ lin ^ e;
  endfunction
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int                WIDTH = 61,
  parameter rng_pkg::lfsr_vec_t TAPS  = '1,
  parameter rng_pkg::lfsr_vec_t SEED  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [2:0] tap_o,
  output logic       alive_o
);
  localparam logic [WIDTH-1:0] TMASK = TAPS[WIDTH-1:0];
  localparam logic [WIDTH-1:0] SEEDW = SEED[WIDTH-1:0];

  logic [WIDTH-1:0] state_q, next_s;

  function automatic logic [WIDTH-1:0] step(logic [WIDTH-1:0] s);
    return {s[WIDTH-2:0], ^(s & TMASK)};
  endfunction

  always_comb begin
    next_s = step(state_q);
    if (next_s == '0) next_s = SEEDW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEEDW;
    else        state_q <= next_s;
  end

  assign tap_o   = {state_q[rng_pkg::TAP_C], state_q[rng_pkg::TAP_B], state_q[rng_pkg::TAP_A]};
  assign alive_o = |state_q;
endmodule

// File: rtl/rng_mixer.sv
module rng_mixer #(
  parameter int N = rng_pkg::NUM_LFSR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         entropy_i,
  input  logic [N-1:0] tap_a_i,
  input  logic [N-1:0] tap_b_i,
  input  logic [N-1:0] tap_c_i,
  output logic         mix_o
);
  logic ent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_q <= 1'b0;
    else        ent_q <= entropy_i;
  end

  assign mix_o = rng_pkg::mix_bit(tap_a_i, tap_b_i, tap_c_i, ent_q);
endmodule

// File: rtl/rng_assembler.sv
module rng_assembler #(
  parameter int WORD_W = rng_pkg::WORD_W,
  parameter int SLOT_W = rng_pkg::SLOT_W,
  parameter int FILL_W = rng_pkg::FILL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  input  logic              start_i,
  output logic [WORD_W-1:0] word_o,
  output logic              ready_o,
  output logic              done_o
);
  logic [FILL_W-1:0] cnt_q;
  logic              par_q;
  logic [WORD_W-1:0] shr_q;
  logic              slot_end, last;
  logic              fold;

  assign slot_end = (cnt_q[SLOT_W-1:0] == '1);
  assign last     = (cnt_q == '1);
  assign fold     = par_q ^ bit_i;
  assign done_o   = !ready_o && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      par_q   <= 1'b0;
      shr_q   <= '0;
      word_o  <= '0;
      ready_o <= 1'b0;
    end else if (ready_o) begin
      if (start_i) begin
        ready_o <= 1'b0;
        cnt_q   <= '0;
        par_q   <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_q + FILL_W'(1);
      if (slot_end) begin
        par_q <= 1'b0;
        if (last) begin
          word_o  <= {shr_q[WORD_W-2:0], fold};
          ready_o <= 1'b1;
        end else begin
          shr_q <= {shr_q[WORD_W-2:0], fold};
        end
      end else begin
        par_q <= fold;
      end
    end
  end
endmodule

// File: rtl/rng_word_gen.sv
module rng_word_gen #(
  parameter int WORD_W = rng_pkg::WORD_W,
  parameter int N      = rng_pkg::NUM_LFSR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entropy_i,
  input  logic              rd_en_i,
  input  logic              priv_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              valid_o
);
  logic [N-1:0]      tap_a, tap_b, tap_c;
  logic [N-1:0]      lfsr_alive;
  logic              mix_bit;
  logic              take;
  logic              fill_done;
  logic [WORD_W-1:0] word_q;

  for (genvar i = 0; i < N; i++) begin : g_lfsr
    logic [2:0] taps;
    rng_lfsr #(
      .WIDTH(rng_pkg::LFSR_LEN[i]),
      .TAPS (rng_pkg::LFSR_TAP[i]),
      .SEED (rng_pkg::LFSR_SEED[i])
    ) u_lfsr (
      .clk    (clk),
      .rst_n  (rst_n),
      .tap_o  (taps),
      .alive_o(lfsr_alive[i])
    );
    assign tap_a[i] = taps[0];
    assign tap_b[i] = taps[1];
    assign tap_c[i] = taps[2];
  end

  rng_mixer #(.N(N)) u_mix (
    .clk      (clk),
    .rst_n    (rst_n),
    .entropy_i(entropy_i),
    .tap_a_i  (tap_a),
    .tap_b_i  (tap_b),
    .tap_c_i  (tap_c),
    .mix_o    (mix_bit)
  );

  assign take = rd_en_i && priv_i && valid_o;

  rng_assembler #(.WORD_W(WORD_W)) u_asm (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_i  (mix_bit),
    .start_i(take),
    .word_o (word_q),
    .ready_o(valid_o),
    .done_o (fill_done)
  );

  assign rd_data_o = (rd_en_i && priv_i) ? word_q : '0;
endmodule

// File: rtl/rng_word_gen_chk.sv
module rng_word_gen_chk #(
  parameter int WORD_W = rng_pkg::WORD_W,
  parameter int N      = rng_pkg::NUM_LFSR
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              priv,
  input logic [WORD_W-1:0] rd_data,
  input logic              valid,
  input logic [WORD_W-1:0] word,
  input logic              done,
  input logic [N-1:0]      alive
);
  logic [rng_pkg::FILL_W:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wait_q <= '0;
    else if (valid) wait_q <= '0;
    else            wait_q <= wait_q + 1'b1;
  end

  AST_UNPRIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && !priv) |-> rd_data == '0); // R2
  AST_UNPRIV_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (valid && !(rd_en && priv)) |=> (valid && $stable(word))); // R3
  AST_TAKE_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (valid && rd_en && priv) |=> !valid); // R4
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) !valid |-> wait_q < (rng_pkg::FILL_W+1)'(rng_pkg::FILL_CYC)); // R5
  AST_DONE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n) done |=> valid); // R5
  AST_BUSY_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n) !valid |=> (valid || $stable(word))); // R7
  AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (!rst_n) alive == '1); // R9
endmodule

bind rng_word_gen rng_word_gen_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rd_en  (rd_en_i),
  .priv   (priv_i),
  .rd_data(rd_data_o),
  .valid  (valid_o),
  .word   (word_q),
  .done   (fill_done),
  .alive  (lfsr_alive)
);

// File: tb/rng_word_gen_test.sv
module rng_word_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        entropy = 1'b0;
  logic        rd_en = 1'b0;
  logic        priv = 1'b0;
  logic [15:0] rd_data;
  logic        valid;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  localparam int FILL = 256;

  always #4 clk = ~clk;

  rng_word_gen uut (
    .clk(clk), .rst_n(rst_n), .entropy_i(entropy), .rd_en_i(rd_en),
    .priv_i(priv), .rd_data_o(rd_data), .valid_o(valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rd_en = 0; priv = 0; entropy = 0; rst_n = 0;
    tick(2);
    rst_n = 1;
  endtask

  // look at the held word through the port without letting a clock edge pass
  task automatic peek(output logic [15:0] w);
    rd_en = 1; priv = 1;
    #1 w = rd_data;
    rd_en = 0; priv = 0;
  endtask

  // privileged read across one edge; returns at the following negedge
  task automatic priv_read(output logic [15:0] w);
    rd_en = 1; priv = 1;
    #1 w = rd_data;
    @(posedge clk);
    @(negedge clk);
    rd_en = 0; priv = 0;
  endtask

  task automatic t_reset_state();
    logic [15:0] w;
    do_reset();
    check(valid == 1'b0, "R1", "flag after reset", valid, 0);
    peek(w);
    check(w == 16'h0, "R1", "data after reset", w, 0);
    tick(FILL - 1);
    check(valid == 1'b0, "R1", "flag before first fill", valid, 0);
    tick(1);
    check(valid == 1'b1, "R1", "flag at first fill", valid, 1);
  endtask

  task automatic t_latency();
    logic [15:0] w;
    priv_read(w);
    check(valid == 1'b0, "R4", "flag after accepted read", valid, 0);
    tick(FILL - 1);
    check(valid == 1'b0, "R5", "flag one cycle early", valid, 0);
    tick(1);
    check(valid == 1'b1, "R5", "flag at 256 cycles", valid, 1);
  endtask

  task automatic t_unpriv();
    logic [15:0] w0, w1;
    peek(w0);
    rd_en = 1; priv = 0;
    #1 check(rd_data == 16'h0, "R2", "unprivileged read data", rd_data, 0);
    tick(5);
    rd_en = 0; priv = 1;
    #1 check(rd_data == 16'h0, "R2", "qualifier without strobe", rd_data, 0);
    tick(2);
    priv = 0;
    check(valid == 1'b1, "R3", "flag after unprivileged reads", valid, 1);
    peek(w1);
    check(w1 == w0, "R3", "word after unprivileged reads", w1, w0);
  endtask

  task automatic t_busy_read();
    logic [15:0] w0, w1, w2, w3;
    peek(w0);
    priv_read(w1);
    check(w1 == w0, "R2", "privileged read data", w1, w0);
    tick(100);
    priv_read(w2);
    check(w2 == w0, "R6", "busy read returns old word", w2, w0);
    tick(FILL - 102);
    check(valid == 1'b0, "R6", "busy read did not finish early", valid, 0);
    tick(1);
    check(valid == 1'b1, "R6", "busy read did not restart fill", valid, 1);
    peek(w2);
    check(w2 != w0, "R7", "word replaced at completion", w2, w0);
    tick(7);
    peek(w3);
    check(w3 == w2, "R7", "word held while flag high", w3, w2);
  endtask

  task automatic t_collision();
    logic [15:0] w0, w1, w2, w3;
    priv_read(w0);
    tick(FILL - 1);
    check(valid == 1'b0, "R6", "flag low before completion edge", valid, 0);
    priv_read(w1);
    check(w1 == w0, "R6", "read at completion edge returns old word", w1, w0);
    check(valid == 1'b1, "R6", "read at completion edge not consumed", valid, 1);
    peek(w2);
    tick(3);
    peek(w3);
    check(w3 == w2, "R7", "new word held after collision", w3, w2);
  endtask

  task automatic run_from_reset(input int p0, input int p1, output logic [15:0] w);
    do_reset();
    for (int k = 1; k <= FILL; k++) begin
      entropy = (k == p0 || k == p1);
      tick(1);
    end
    entropy = 0;
    check(valid == 1'b1, "R8", "word ready after run", valid, 1);
    peek(w);
  endtask

  task automatic t_entropy();
    logic [15:0] a, b, c, d;
    run_from_reset(0, 0, a);
    run_from_reset(0, 0, b);
    check(a == b, "R8", "identical entropy gives identical word", b, a);
    run_from_reset(40, 0, c);
    check($countones(a ^ c) == 1, "R8", "one flipped sample flips one bit", $countones(a ^ c), 1);
    run_from_reset(40, 41, d);
    check(d == a, "R8", "two flips in one slot cancel", d, a);
  endtask

  task automatic t_progress();
    logic [15:0] w [4];
    for (int k = 0; k < 4; k++) begin
      priv_read(w[k]);
      tick(FILL);
    end
    for (int i = 0; i < 4; i++)
      for (int j = i + 1; j < 4; j++)
        check(w[i] != w[j], "R9", "successive words differ", w[i], w[j]);
  endtask

  initial begin
    t_reset_state();
    t_latency();
    t_unpriv();
    t_busy_read();
    t_collision();
    t_entropy();
    t_progress();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule